// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects a vector of interrupt and exception request lines. It gives each line its own programmable priority and enable, and it presents a single interrupt line to the processor core. A rising edge on a request line latches that source as pending. The controller picks the most urgent enabled pending source and drives its number on a vector output alongside the interrupt line. A smaller priority value means a more urgent source.

The controller keeps a stack of the priorities of handlers that are running. When the core accepts an interrupt with an acknowledge strobe, the winner's priority is pushed and its pending bit is cleared. When a handler finishes, the core sends a completion strobe and the top entry is popped. A new request interrupts a running handler only when its priority value is strictly smaller than the top of the stack. Handlers therefore nest, and each interrupted handler takes up again after the more urgent one completes. Saving registers to memory and fetching handler addresses are left to the core.

Top module: `preempt_irq_ctrl`

## Requirements
- R1: A source becomes pending on a 0-to-1 transition of its request line. A line held high after its acknowledge does not make the source pending again.
- R2: A source whose enable is 0 still latches pending but never wins arbitration. Enabling it later makes it eligible without a new request edge.
- R3: Among enabled pending sources, the one with the smallest priority value is chosen.
- R4: When enabled pending sources share the smallest priority value, the lowest source number is chosen.
- R5: With no handler active, `irqOut` is 1 whenever any enabled source is pending, and `irqVec` carries the chosen source number.
- R6: `ackIn` while `irqOut` is 1 clears the chosen source's pending bit and pushes its priority on the active stack. `ackIn` while `irqOut` is 0 has no effect.
- R7: While a handler is active, `irqOut` is 1 only if the chosen source's priority value is strictly smaller than the top of the active stack. Equal or larger values are held pending.
- R8: `doneIn` pops the active stack. The previous level then governs preemption again, and held requests are offered once they qualify.
- R9: After reset, no source is pending, every source is disabled with priority 0, the stack is empty, and `irqOut` is 0.
- R10: `irqVec` reads 0 whenever `irqOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | Request lines, edge-detected per source |
| cfgWe | input | 1 | Write strobe for one source's configuration |
| cfgIdx | input | 8 | Source number being configured |
| cfgPrio | input | PRIO_W | Priority value to store (smaller is more urgent) |
| cfgEn | input | 1 | Enable value to store |
| ackIn | input | 1 | Core accepts the offered interrupt |
| doneIn | input | 1 | Core finished the innermost handler |
| irqOut | output | 1 | Interrupt line to the core |
| irqVec | output | 8 | Number of the offered source |

## Verification
A request edge or a configuration write is sampled at one rising edge, and `irqOut`/`irqVec` reflect it right after that same edge. The outputs are combinational from registered state, so the latency is one edge. An acknowledge or completion strobe likewise changes the stack and pending bits at its edge, and the re-evaluated offer is visible immediately afterward. The bench drives every stimulus on a falling edge, lets exactly one rising edge pass, removes the stimulus, and samples the outputs on the next falling edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int VEC_W = 8;

  // Strobe from control to datapath: retire the pending bit of one source
  typedef struct packed {
    logic             take;
    logic [VEC_W-1:0] idx;
  } takeStrb_t;
endpackage

// File: rtl/irq_ctrl_dp.sv
module irq_ctrl_dp
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic              cfgWe,
  input  logic [VEC_W-1:0]  cfgIdx,
  input  logic [PRIO_W-1:0] cfgPrio,
  input  logic              cfgEn,
  input  takeStrb_t         strb,
  output logic              bestValid,
  output logic [VEC_W-1:0]  bestIdx,
  output logic [PRIO_W-1:0] bestPrio
);
  logic [NUM_SRC-1:0] reqPrev, pending, enReg, reqEdge, clrMask;
  logic [PRIO_W-1:0]  prioReg [NUM_SRC];

  assign reqEdge = reqIn & ~reqPrev;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign clrMask[i] = strb.take && (strb.idx == VEC_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enReg[i]   <= 1'b0;
        prioReg[i] <= '0;
      end else if (cfgWe && cfgIdx == VEC_W'(i)) begin
        enReg[i]   <= cfgEn;
        prioReg[i] <= cfgPrio;
      end
    end

    // R1: an edge always latches pending
    p_edge_latch_r1: assert property (@(posedge clk) disable iff (!rstN)
      reqEdge[i] |=> pending[i]);
    // R6: an acknowledged source is retired unless a fresh edge arrives
    p_take_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
      clrMask[i] && !reqEdge[i] |=> !pending[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev <= '0;
      pending <= '0;
    end else begin
      reqPrev <= reqIn;
      pending <= (pending & ~clrMask) | reqEdge;
    end
  end

  // Arbiter: strict compare keeps the lowest index on equal priority
  always_comb begin
    logic              found;
    logic [PRIO_W-1:0] bp;
    logic [VEC_W-1:0]  bi;
    found = 1'b0;
    bp    = '1;
    bi    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && enReg[i] && (!found || prioReg[i] < bp)) begin
        found = 1'b1;
        bp    = prioReg[i];
        bi    = VEC_W'(i);
      end
    end
    bestValid = found;
    bestPrio  = bp;
    bestIdx   = bi;
  end

  // R2: the offered source is always an enabled, pending one
  p_winner_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    bestValid |-> (enReg[bestIdx[$clog2(NUM_SRC)-1:0]] && pending[bestIdx[$clog2(NUM_SRC)-1:0]]));
endmodule

// File: rtl/irq_ctrl_ctl.sv
module irq_ctrl_ctl
  import irq_ctrl_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ackIn,
  input  logic              doneIn,
  input  logic              bestValid,
  input  logic [VEC_W-1:0]  bestIdx,
  input  logic [PRIO_W-1:0] bestPrio,
  output logic              irqOut,
  output logic [VEC_W-1:0]  irqVec,
  output takeStrb_t         strb
);
  localparam int DEPTH = 1 << PRIO_W;
  localparam int SP_W  = (PRIO_W < 1) ? 1 : PRIO_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PRIO_W-1:0] stk [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [SP_W-1:0]   topPtr, wrPtr;
  logic [PRIO_W-1:0] topPrio;
  logic              push, pop;

  assign topPtr  = SP_W'(cnt - CNT_W'(1));
  assign topPrio = stk[topPtr];
  assign irqOut  = bestValid && ((cnt == '0) || (bestPrio < topPrio));
  assign irqVec  = irqOut ? bestIdx : '0;
  assign push    = ackIn && irqOut;
  assign pop     = doneIn && (cnt != '0);
  assign wrPtr   = pop ? topPtr : SP_W'(cnt);

  assign strb.take = push;
  assign strb.idx  = bestIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      if (push) stk[wrPtr] <= bestPrio;
      if (push && !pop)      cnt <= cnt + CNT_W'(1);
      else if (pop && !push) cnt <= cnt - CNT_W'(1);
    end
  end

  // R6: an accepted interrupt deepens the stack by one
  p_push_depth_r6: assert property (@(posedge clk) disable iff (!rstN)
    push && !pop |=> cnt == $past(cnt) + CNT_W'(1));
  // R7: each nested level is strictly more urgent than the one below
  p_nest_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    push && !pop && (cnt != '0) |=> topPrio < $past(topPrio));
  // R8: completion removes exactly one level
  p_pop_depth_r8: assert property (@(posedge clk) disable iff (!rstN)
    pop && !push |=> cnt == $past(cnt) - CNT_W'(1));
  // R7: strict ordering bounds the depth by the number of priority levels
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/preempt_irq_ctrl.sv
module preempt_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    reqIn,
  input  logic                  cfgWe,
  input  logic [VEC_W-1:0]      cfgIdx,
  input  logic [PRIO_W-1:0]     cfgPrio,
  input  logic                  cfgEn,
  input  logic                  ackIn,
  input  logic                  doneIn,
  output logic                  irqOut,
  output logic [VEC_W-1:0]      irqVec
);
  takeStrb_t         strb;
  logic              bestValid;
  logic [VEC_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;

  irq_ctrl_dp #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgPrio(cfgPrio), .cfgEn(cfgEn),
    .strb(strb), .bestValid(bestValid), .bestIdx(bestIdx), .bestPrio(bestPrio)
  );

  irq_ctrl_ctl #(.PRIO_W(PRIO_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ackIn(ackIn), .doneIn(doneIn),
    .bestValid(bestValid), .bestIdx(bestIdx), .bestPrio(bestPrio),
    .irqOut(irqOut), .irqVec(irqVec), .strb(strb)
  );

  // R10: no vector is shown without the interrupt line
  p_idle_vec_r10: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (irqVec == '0));
endmodule

// File: tb/preempt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module preempt_irq_ctrl_bench;
  localparam int NSRC = 16;
  localparam int PW   = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] reqIn = '0;
  logic            cfgWe = 1'b0;
  logic [7:0]      cfgIdx = '0;
  logic [PW-1:0]   cfgPrio = '0;
  logic            cfgEn = 1'b0;
  logic            ackIn = 1'b0;
  logic            doneIn = 1'b0;
  logic            irqOut;
  logic [7:0]      irqVec;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  preempt_irq_ctrl #(.NUM_SRC(NSRC), .PRIO_W(PW)) u_preempt_irq_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgPrio(cfgPrio), .cfgEn(cfgEn),
    .ackIn(ackIn), .doneIn(doneIn), .irqOut(irqOut), .irqVec(irqVec)
  );

  localparam logic [1:0] OP_PULSE = 2'd0, OP_ACK = 2'd1, OP_DONE = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] mask;
    logic        expIrq;
    logic [7:0]  expVec;
    logic [3:0]  req;
  } stepT;

  // Sources 0..4 enabled with priorities 5,3,3,6,1; source 5 disabled
  localparam stepT TBL [0:14] = '{
    '{OP_PULSE, 16'h0008, 1'b1, 8'd3, 4'd5},  // R5 single source offered
    '{OP_PULSE, 16'h0001, 1'b1, 8'd0, 4'd3},  // R3 prio 5 beats prio 6
    '{OP_PULSE, 16'h0006, 1'b1, 8'd1, 4'd4},  // R4 tie on prio 3, lower index
    '{OP_ACK,   16'h0000, 1'b0, 8'd0, 4'd7},  // R7 equal prio held; R10 vec 0
    '{OP_PULSE, 16'h0010, 1'b1, 8'd4, 4'd7},  // R7 prio 1 preempts level 3
    '{OP_ACK,   16'h0000, 1'b0, 8'd0, 4'd6},  // R6 nested push to level 1
    '{OP_DONE,  16'h0000, 1'b0, 8'd0, 4'd8},  // R8 back to level 3, src2 held
    '{OP_DONE,  16'h0000, 1'b1, 8'd2, 4'd8},  // R8 empty, src2 offered
    '{OP_ACK,   16'h0000, 1'b0, 8'd0, 4'd6},  // R6 src2 retired, prio5 held
    '{OP_DONE,  16'h0000, 1'b1, 8'd0, 4'd8},  // R8 src0 offered
    '{OP_ACK,   16'h0000, 1'b0, 8'd0, 4'd7},  // R7 prio 6 held under 5
    '{OP_DONE,  16'h0000, 1'b1, 8'd3, 4'd8},  // R8 src3 offered
    '{OP_ACK,   16'h0000, 1'b0, 8'd0, 4'd6},  // R6 last one retired
    '{OP_DONE,  16'h0000, 1'b0, 8'd0, 4'd10}, // R10 idle, vec 0
    '{OP_PULSE, 16'h0020, 1'b0, 8'd0, 4'd2}   // R2 disabled source not offered
  };

  task automatic check(input string tag, input logic expIrq, input logic [7:0] expVec);
    checks++;
    if (irqOut !== expIrq || irqVec !== expVec) begin
      errors++;
      $display("FAIL %s: irqOut=%0b irqVec=%0d expected irqOut=%0b irqVec=%0d",
               tag, irqOut, irqVec, expIrq, expVec);
    end
  endtask

  task automatic setCfg(input int idx, input int prio, input logic en);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 8'(idx); cfgPrio = PW'(prio); cfgEn = en;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic step(input logic [1:0] op, input logic [15:0] mask);
    @(negedge clk);
    case (op)
      OP_PULSE: reqIn = reqIn | mask;
      OP_ACK:   ackIn = 1'b1;
      default:  doneIn = 1'b1;
    endcase
    @(negedge clk);
    reqIn = reqIn & ~mask;
    ackIn = 1'b0;
    doneIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset idle", 1'b0, 8'd0);
    step(OP_PULSE, 16'h0001);
    check("R9 reset leaves sources disabled", 1'b0, 8'd0);
    // R9: reset again to clear the pending bit left by the probe
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    setCfg(0, 5, 1'b1);
    setCfg(1, 3, 1'b1);
    setCfg(2, 3, 1'b1);
    setCfg(3, 6, 1'b1);
    setCfg(4, 1, 1'b1);
    check("R5 nothing pending", 1'b0, 8'd0);

    for (int k = 0; k < 15; k++) begin
      step(TBL[k].op, TBL[k].mask);
      check($sformatf("R%0d table step %0d", TBL[k].req, k), TBL[k].expIrq, TBL[k].expVec);
    end

    // R6: acknowledge with the line low changes nothing
    step(OP_ACK, 16'h0000);
    check("R6 ack while idle ignored", 1'b0, 8'd0);

    // R2: enabling a latched source offers it without a new edge
    setCfg(5, 2, 1'b1);
    check("R2 enable exposes latched source", 1'b1, 8'd5);

    // R1: level held high after acknowledge does not re-latch
    @(negedge clk);
    reqIn[5] = 1'b1;
    step(OP_ACK, 16'h0000);
    check("R6 ack retires src5", 1'b0, 8'd0);
    step(OP_DONE, 16'h0000);
    check("R1 held level does not re-latch", 1'b0, 8'd0);

    // R1: a new rising edge latches again
    @(negedge clk);
    reqIn[5] = 1'b0;
    step(OP_PULSE, 16'h0020);
    check("R1 new edge latches", 1'b1, 8'd5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog R0: run did not end, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule